// File: doc/BRIEF.md
# Two-Thread Shared Functional Unit Selector

This block sits in front of one functional unit, such as an integer ALU, a floating-point ALU or a load/store unit, that two thread pipelines share. Each thread presents an operation with a valid/ready handshake. When the unit can take work and only one thread asks, that operation goes straight in. When both threads ask in the same cycle, or the unit is still busy, the operations that cannot go in are parked in a one-entry holding slot for each thread. The thread's upstream stages can then keep going, and the parked operation is sent to the unit as soon as the unit finishes.

The unit is treated as non-pipelined with a fixed latency set by a parameter (1 for a simple integer unit, 4 for a floating-point unit, for example). While an operation is in flight, the selector holds the opcode and operands steady on the unit's inputs. It samples the unit's result on the last cycle of the latency window. Each result comes back as a one-cycle pulse tagged with the thread that issued it.

Top module: `fu_selector`

## Requirements
- R1: After reset both ready outputs are high, `res_valid` is low and `fu_start` is low.
- R2: A single request accepted while the unit is idle is issued at the accepting clock edge. Its result appears on `res_valid` exactly LAT edges later, carrying `res_tid` equal to the issuing thread (0 for the t0 port, 1 for the t1 port) and `res_data` equal to the unit's output for those operands.
- R3: When two requests meet in the same cycle, one is granted and the other is parked, so at least one ready output is low in the following cycle. A parked operation is issued on the edge at which the running operation completes.
- R4: When two candidates of the same kind (both new, or both parked) compete, the grant alternates. The first such tie after reset goes to thread 0, and each tie hands priority to the loser for the next tie.
- R5: A parked operation is granted ahead of a new request from the other thread that arrives in the same cycle.
- R6: A thread's ready output is low while its slot is occupied, and it falls only after that thread presented a request. A request presented while ready is low is ignored and produces no result.
- R7: At most one operation is in flight. `fu_start` pulses only when the unit is idle or is finishing, and `fu_op`, `fu_a` and `fu_b` stay stable between starts.
- R8: Every issued operation yields exactly one one-cycle `res_valid` pulse, LAT cycles after its `fu_start` pulse, tagged with the thread shown on `fu_tid` at that start.
- R9: Operations from one thread complete in the order that thread presented them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_valid | input | 1 | Thread 0 request valid |
| t0_ready | output | 1 | Thread 0 slot free |
| t0_op | input | OP_W | Thread 0 opcode |
| t0_a | input | DATA_W | Thread 0 operand A |
| t0_b | input | DATA_W | Thread 0 operand B |
| t1_valid | input | 1 | Thread 1 request valid |
| t1_ready | output | 1 | Thread 1 slot free |
| t1_op | input | OP_W | Thread 1 opcode |
| t1_a | input | DATA_W | Thread 1 operand A |
| t1_b | input | DATA_W | Thread 1 operand B |
| fu_start | output | 1 | One-cycle pulse: a new operation enters the unit |
| fu_tid | output | 1 | Thread owning the operation in the unit |
| fu_op | output | OP_W | Opcode held to the unit |
| fu_a | output | DATA_W | Operand A held to the unit |
| fu_b | output | DATA_W | Operand B held to the unit |
| fu_result | input | DATA_W | Unit output, sampled on the final latency cycle |
| res_valid | output | 1 | One-cycle result pulse |
| res_tid | output | 1 | Thread that issued the result |
| res_data | output | DATA_W | Result value |

## Verification
The selector is driven with the following patterns, each of which separates a different piece of the grant logic:
- A lone request sets the baseline latency and tag.
- A simultaneous pair on an idle unit, repeated, shows that ties alternate rather than always favouring one side.
- A second request from the same thread while the unit is busy fills that thread's slot, and a third request held during the stall must vanish. This tells a proper ready stall apart from a slot being overwritten.
- A new request arriving exactly when a parked request from the other thread is dispatched separates "parked first" from "new first".
- Both slots filling while the unit is busy checks the round-robin among parked work and same-thread ordering.

// File: rtl/fus_pkg.sv
package fus_pkg;
  typedef enum logic {
    TID0 = 1'b0,
    TID1 = 1'b1
  } tid_e;

  function automatic tid_e tid_flip(input tid_e t);
    return (t == TID0) ? TID1 : TID0;
  endfunction
endpackage

// File: rtl/fus_slot.sv
module fus_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         clear,
  output logic         valid,
  output logic [W-1:0] data
);
  logic         v_q, v_d;
  logic [W-1:0] d_q;

  always_comb begin
    v_d = v_q;
    if (load)       v_d = 1'b1;
    else if (clear) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (load) d_q <= load_data;
  end

  assign valid = v_q;
  assign data  = d_q;
endmodule

// File: rtl/fus_arb.sv
module fus_arb
  import fus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_ok,
  input  logic [1:0] slot_v,
  input  logic [1:0] new_v,
  output logic       issue,
  output tid_e       win,
  output logic       from_slot,
  output logic [1:0] park
);
  tid_e       rr_q, rr_d;
  logic [1:0] cand;
  logic       tie;

  always_comb begin
    from_slot = |slot_v;
    cand      = from_slot ? slot_v : new_v;
    tie       = &cand;
    if (tie)          win = rr_q;
    else if (cand[1]) win = TID1;
    else              win = TID0;
    issue = issue_ok && (|cand);
    for (int t = 0; t < 2; t++) begin
      park[t] = new_v[t] && !(issue && !from_slot && (win == tid_e'(t)));
    end
    rr_d = (issue && tie) ? tid_flip(win) : rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= TID0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/fus_exec.sv
module fus_exec #(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_tid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [DATA_W-1:0] issue_a,
  input  logic [DATA_W-1:0] issue_b,
  input  logic [DATA_W-1:0] fu_result,
  output logic              issue_ok,
  output logic              fu_start,
  output logic              fu_tid,
  output logic [OP_W-1:0]   fu_op,
  output logic [DATA_W-1:0] fu_a,
  output logic [DATA_W-1:0] fu_b,
  output logic              res_valid,
  output logic              res_tid,
  output logic [DATA_W-1:0] res_data
);
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q;
  logic             tid_q;
  logic [OP_W-1:0]  op_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic             rv_q, rtid_q;
  logic [DATA_W-1:0] rd_q;
  logic             done_now;

  assign done_now = busy_q && (cnt_q == CNT_LAST);
  assign issue_ok = !busy_q || done_now;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (issue) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done_now) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      start_q <= issue;
      rv_q    <= done_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q <= 1'b0;
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (issue) begin
      tid_q <= issue_tid;
      op_q  <= issue_op;
      a_q   <= issue_a;
      b_q   <= issue_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtid_q <= 1'b0;
      rd_q   <= '0;
    end else if (done_now) begin
      rtid_q <= tid_q;
      rd_q   <= fu_result;
    end
  end

  assign fu_start  = start_q;
  assign fu_tid    = tid_q;
  assign fu_op     = op_q;
  assign fu_a      = a_q;
  assign fu_b      = b_q;
  assign res_valid = rv_q;
  assign res_tid   = rtid_q;
  assign res_data  = rd_q;
endmodule

// File: rtl/fu_selector.sv
module fu_selector
  import fus_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0_valid,
  output logic              t0_ready,
  input  logic [OP_W-1:0]   t0_op,
  input  logic [DATA_W-1:0] t0_a,
  input  logic [DATA_W-1:0] t0_b,
  input  logic              t1_valid,
  output logic              t1_ready,
  input  logic [OP_W-1:0]   t1_op,
  input  logic [DATA_W-1:0] t1_a,
  input  logic [DATA_W-1:0] t1_b,
  output logic              fu_start,
  output logic              fu_tid,
  output logic [OP_W-1:0]   fu_op,
  output logic [DATA_W-1:0] fu_a,
  output logic [DATA_W-1:0] fu_b,
  input  logic [DATA_W-1:0] fu_result,
  output logic              res_valid,
  output logic              res_tid,
  output logic [DATA_W-1:0] res_data
);
  localparam int PK_W = OP_W + 2 * DATA_W;

  logic [PK_W-1:0] req_pk  [2];
  logic [PK_W-1:0] slot_pk [2];
  logic [1:0]      req_v, slot_v, new_v, park, clr;
  logic            issue, from_slot, issue_ok;
  tid_e            win;
  logic [PK_W-1:0] iss_pk;

  assign req_pk[0] = {t0_op, t0_a, t0_b};
  assign req_pk[1] = {t1_op, t1_a, t1_b};
  assign req_v     = {t1_valid, t0_valid};
  assign new_v     = req_v & ~slot_v;

  for (genvar t = 0; t < 2; t++) begin : g_slot
    assign clr[t] = issue && from_slot && (win == tid_e'(t));
    fus_slot #(.W(PK_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (park[t]),
      .load_data(req_pk[t]),
      .clear    (clr[t]),
      .valid    (slot_v[t]),
      .data     (slot_pk[t])
    );
  end

  assign t0_ready = !slot_v[0];
  assign t1_ready = !slot_v[1];

  fus_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_ok (issue_ok),
    .slot_v   (slot_v),
    .new_v    (new_v),
    .issue    (issue),
    .win      (win),
    .from_slot(from_slot),
    .park     (park)
  );

  assign iss_pk = from_slot ? slot_pk[win] : req_pk[win];

  fus_exec #(.OP_W(OP_W), .DATA_W(DATA_W), .LAT(LAT)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .issue_tid(win == TID1),
    .issue_op (iss_pk[PK_W-1 -: OP_W]),
    .issue_a  (iss_pk[2*DATA_W-1 -: DATA_W]),
    .issue_b  (iss_pk[DATA_W-1:0]),
    .fu_result(fu_result),
    .issue_ok (issue_ok),
    .fu_start (fu_start),
    .fu_tid   (fu_tid),
    .fu_op    (fu_op),
    .fu_a     (fu_a),
    .fu_b     (fu_b),
    .res_valid(res_valid),
    .res_tid  (res_tid),
    .res_data (res_data)
  );
endmodule

// File: rtl/fus_chk.sv
module fus_chk #(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              t0_valid,
  input logic              t0_ready,
  input logic              t1_valid,
  input logic              t1_ready,
  input logic              fu_start,
  input logic              fu_tid,
  input logic [OP_W-1:0]   fu_op,
  input logic [DATA_W-1:0] fu_a,
  input logic [DATA_W-1:0] fu_b,
  input logic              res_valid,
  input logic              res_tid
);
  localparam int AGE_W = $clog2(LAT + 1) + 1;
  localparam logic [AGE_W-1:0] AGE_END = AGE_W'(LAT);

  logic [AGE_W-1:0] age_q;
  logic             own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      own_q <= 1'b0;
    end else begin
      if (fu_start)                               age_q <= AGE_W'(1);
      else if (age_q != '0 && age_q != AGE_END)   age_q <= age_q + 1'b1;
      else                                        age_q <= '0;
      if (fu_start) own_q <= fu_tid;
    end
  end

  // R3
  pair_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_valid && t1_valid && t0_ready && t1_ready) |=> !(t0_ready && t1_ready));

  // R6
  t0_ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t0_ready) |-> $past(t0_valid));

  // R6
  t1_ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(t1_ready) |-> $past(t1_valid));

  // R7
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |-> (age_q == '0 || age_q == AGE_END));

  // R7
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fu_start && age_q != '0) |-> ($stable(fu_a) && $stable(fu_b) && $stable(fu_op)));

  // R8
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (age_q == AGE_END));

  // R8
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_END) |-> res_valid);

  // R8
  result_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_tid == own_q));
endmodule

bind fu_selector fus_chk #(.OP_W(OP_W), .DATA_W(DATA_W), .LAT(LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .t0_valid (t0_valid),
  .t0_ready (t0_ready),
  .t1_valid (t1_valid),
  .t1_ready (t1_ready),
  .fu_start (fu_start),
  .fu_tid   (fu_tid),
  .fu_op    (fu_op),
  .fu_a     (fu_a),
  .fu_b     (fu_b),
  .res_valid(res_valid),
  .res_tid  (res_tid)
);

// File: tb/fu_selector_tb.sv
`timescale 1ns/1ps
module fu_selector_tb;
  localparam int OP_W = 4, DATA_W = 16, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic t0_valid = 1'b0, t1_valid = 1'b0;
  logic [OP_W-1:0] t0_op = '0, t1_op = '0;
  logic [DATA_W-1:0] t0_a = '0, t0_b = '0, t1_a = '0, t1_b = '0;
  logic t0_ready, t1_ready, fu_start, fu_tid, res_valid, res_tid;
  logic [OP_W-1:0] fu_op;
  logic [DATA_W-1:0] fu_a, fu_b, fu_result, res_data;

  int n_chk = 0, n_bad = 0, cyc = 0, n_log = 0;
  int log_tid [16];
  int log_dat [16];
  int log_cyc [16];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // unit model: sum of operands plus opcode
  assign fu_result = fu_a + fu_b + DATA_W'(fu_op);

  fu_selector #(.OP_W(OP_W), .DATA_W(DATA_W), .LAT(LAT)) u_dut (.*);

  always @(negedge clk) begin
    if (rst_n && res_valid && n_log < 16) begin
      log_tid[n_log] = int'(res_tid);
      log_dat[n_log] = int'(res_data);
      log_cyc[n_log] = cyc;
      n_log = n_log + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic exp_res(input int i, input int tid, input int dat, input int c, input string req);
    check(log_tid[i] == tid, req, log_tid[i], tid);
    check(log_dat[i] == dat, req, log_dat[i], dat);
    check(log_cyc[i] == c, req, log_cyc[i], c);
  endtask

  task automatic put0(input logic v, input int op, input int a, input int b);
    t0_valid = v; t0_op = OP_W'(op); t0_a = DATA_W'(a); t0_b = DATA_W'(b);
  endtask

  task automatic put1(input logic v, input int op, input int a, input int b);
    t1_valid = v; t1_op = OP_W'(op); t1_a = DATA_W'(a); t1_b = DATA_W'(b);
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
    n_log = 0;
  endtask

  task automatic t_reset();
    check(t0_ready && t1_ready, "R1 ready", int'({t1_ready, t0_ready}), 3);
    check(!res_valid && !fu_start, "R1 idle", int'({fu_start, res_valid}), 0);
  endtask

  task automatic t_single();
    int k;
    settle();
    @(negedge clk); k = cyc + 1; put0(1, 3, 100, 20);
    @(negedge clk); put0(0, 0, 0, 0);
    repeat (10) @(negedge clk);
    check(n_log == 1, "R2 count", n_log, 1);
    exp_res(0, 0, 123, k + LAT, "R2");
  endtask

  task automatic t_pair(input int first, input string req);
    int k;
    settle();
    @(negedge clk); k = cyc + 1; put0(1, 1, 10, 1); put1(1, 2, 50, 5);
    @(negedge clk); put0(0, 0, 0, 0); put1(0, 0, 0, 0);
    check((first == 0) ? (!t1_ready && t0_ready) : (!t0_ready && t1_ready),
          "R3 parked ready", int'({t1_ready, t0_ready}), (first == 0) ? 1 : 2);
    repeat (12) @(negedge clk);
    check(n_log == 2, "R3 count", n_log, 2);
    exp_res(0, first, (first == 0) ? 12 : 57, k + LAT, req);
    exp_res(1, 1 - first, (first == 0) ? 57 : 12, k + 2 * LAT, "R3");
  endtask

  task automatic t_stall();
    int k;
    settle();
    @(negedge clk); k = cyc + 1; put0(1, 0, 1, 2);
    @(negedge clk); put0(1, 0, 4, 4);
    @(negedge clk); put0(1, 0, 9, 9);
    check(!t0_ready, "R6 ready low", int'(t0_ready), 0);
    @(negedge clk);
    check(!t0_ready, "R6 ready held", int'(t0_ready), 0);
    put0(0, 0, 0, 0);
    repeat (14) @(negedge clk);
    check(n_log == 2, "R6 ignored", n_log, 2);
    exp_res(0, 0, 3, k + LAT, "R9");
    exp_res(1, 0, 8, k + 2 * LAT, "R9");
  endtask

  task automatic t_buffer_first();
    int k;
    settle();
    @(negedge clk); k = cyc + 1; put0(1, 0, 2, 3);
    @(negedge clk); put0(0, 0, 0, 0); put1(1, 0, 20, 20);
    @(negedge clk); put1(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    put0(1, 0, 30, 30);
    @(negedge clk); put0(0, 0, 0, 0);
    repeat (14) @(negedge clk);
    check(n_log == 3, "R5 count", n_log, 3);
    exp_res(0, 0, 5, k + LAT, "R5");
    exp_res(1, 1, 40, k + 2 * LAT, "R5");
    exp_res(2, 0, 60, k + 3 * LAT, "R5");
  endtask

  task automatic t_both_slots();
    int k;
    settle();
    @(negedge clk); k = cyc + 1; put0(1, 0, 5, 5);
    @(negedge clk); put0(1, 0, 6, 6); put1(1, 0, 7, 7);
    @(negedge clk); put0(0, 0, 0, 0); put1(0, 0, 0, 0);
    check(!t0_ready && !t1_ready, "R3 both parked", int'({t1_ready, t0_ready}), 0);
    repeat (16) @(negedge clk);
    check(n_log == 3, "R4 count", n_log, 3);
    exp_res(0, 0, 10, k + LAT, "R9");
    exp_res(1, 0, 12, k + 2 * LAT, "R4");
    exp_res(2, 1, 14, k + 3 * LAT, "R4");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_pair(0, "R4 first tie");
    t_pair(1, "R4 alternation");
    t_stall();
    t_buffer_first();
    t_both_slots();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule